// File: doc/BRIEF.md
# Simplicial Piecewise-Linear Neighbourhood Evaluator

The block evaluates a piecewise-linear function of the nine samples of a 3x3 pixel neighbourhood. These are the centre pixel and its eight neighbours. On a start strobe it captures the nine 8-bit samples. It then sweeps an 8-bit ramp upward, one step per clock. On every step the nine comparisons "sample at or above ramp" form a 9-bit vertex code. Each comparison is a corner coordinate of the cube whose corners are all -1/+1 points. The vertex code addresses a 512-entry table that holds one bit per entry.

Interpolation over the simplex that holds the input needs no multiplier. An accumulator counts the ramp steps during which the addressed table bit is 1. Each vertex value therefore carries a weight equal to the share of the sweep for which its code is present. As the ramp rises, a comparator bit can only fall from 1 to 0. A sweep therefore visits at most ten distinct codes. The table is loaded through a simple write port while the block is idle, and it then describes any Boolean or grey-level function.

Top module: `pwl_simplex_eval`

## Requirements
- R1: After synchronous reset, `res` is 0, `res_vld` is 0 and every table entry is 0.
- R2: Input i is `samples[8*i+7:8*i]`. During a sweep the ramp takes the values 0 to 255, one per clock. Vertex code bit i is 1 when input i is greater than or equal to the ramp. Code bit i is table address bit i. For example, with only entry 511 set, the result is the smallest input plus one.
- R3: The table has 512 one-bit entries. A write stores `wr_data` at `wr_addr` when `wr_en` is high and no evaluation is running. Each ramp step reads the entry addressed by the current vertex code.
- R4: Within one sweep the vertex code never gains a 1 bit, so at most 10 distinct codes appear.
- R5: The result is the number of ramp steps whose table bit is 1, saturated at 255.
- R6: A table write issued while an evaluation is running is ignored. It affects neither that result nor later ones.
- R7: `res_vld` is high for exactly one clock, 256 clocks after the edge that accepted `start`. `res` holds its value until the next result.
- R8: A `start` pulse while an evaluation is running is ignored. The running sweep completes on its original schedule.
- R9: The samples are captured at the accepted start. Later changes on `samples` do not affect that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an evaluation (when idle) |
| samples | input | 72 | Nine 8-bit samples, input i at bits 8i+7..8i |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | 9 | Table write address |
| wr_data | input | 1 | Table write bit |
| res | output | 8 | Interpolated result |
| res_vld | output | 1 | One-clock result strobe |

## Verification
Every result is due exactly 256 clocks after the rising edge that accepts `start`. The bench driver notes the cycle count when it raises `start` and queues the expected value together with that count plus 257, which is the falling edge that follows the result's rising edge. The monitor samples on falling edges. It compares both the value and the arrival cycle, and it flags a strobe that arrives with nothing queued or an entry whose due cycle has passed. Disturbances that must be ignored are a second start, a table write or a change of samples. The bench applies them about a hundred cycles into a sweep. It observes them through that result and through the next one.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
    localparam int N_IN   = 9;
    localparam int DW     = 8;
    localparam int DEPTH  = 1 << N_IN;
    localparam int STEPS  = 1 << DW;
    localparam int ACC_W  = DW + 1;
    localparam int CHG_W  = $clog2(N_IN + 2);

    typedef logic [N_IN-1:0]    vcode_t;
    typedef logic [DW-1:0]      level_t;
    typedef logic [N_IN*DW-1:0] nbhd_t;
    typedef logic [ACC_W-1:0]   acc_t;

    typedef enum logic { ST_IDLE, ST_SWEEP } ctl_state_e;

    typedef struct packed {
        logic   wen;
        vcode_t addr;
        logic   data;
    } tbl_wr_t;

    function automatic level_t clip_acc(acc_t a);
        return a[ACC_W-1] ? '1 : a[DW-1:0];
    endfunction
endpackage

// File: rtl/pwl_vertex_gen.sv
module pwl_vertex_gen
    import pwl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   running,
    input  nbhd_t  samples,
    output vcode_t code,
    output level_t ramp,
    output logic   last
);
    nbhd_t  samp_q;
    level_t ramp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= '0;
            ramp_q <= '0;
        end else if (load) begin
            samp_q <= samples;
            ramp_q <= '0;
        end else if (running) begin
            ramp_q <= ramp_q + 1'b1;
        end
    end

    for (genvar g = 0; g < N_IN; g++) begin : g_cmp
        assign code[g] = (samp_q[g*DW +: DW] >= ramp_q);
    end

    assign ramp = ramp_q;
    assign last = running && (ramp_q == '1);

    // Checker state: previous code and count of code changes in a sweep
    vcode_t            code_d;
    logic              run_d;
    logic [CHG_W-1:0]  n_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_d <= '0;
            run_d  <= 1'b0;
            n_chg  <= '0;
        end else begin
            code_d <= code;
            run_d  <= running;
            if (load)
                n_chg <= '0;
            else if (running && run_d && code != code_d && n_chg != '1)
                n_chg <= n_chg + 1'b1;
        end
    end

    p_code_monotone_r4: assert property (@(posedge clk) disable iff (rst)
        (running && run_d) |-> ((code & ~code_d) == '0));

    p_few_codes_r4: assert property (@(posedge clk) disable iff (rst)
        running |-> (n_chg <= CHG_W'(N_IN)));

    p_first_full_r2: assert property (@(posedge clk) disable iff (rst)
        (running && !run_d) |-> (code == '1));
endmodule

// File: rtl/pwl_param_mem.sv
module pwl_param_mem
    import pwl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  tbl_wr_t wr,
    input  vcode_t  rd_addr,
    output logic    rd_bit
);
    logic [DEPTH-1:0] tbl_q;

    always_ff @(posedge clk) begin
        if (rst)
            tbl_q <= '0;
        else if (wr.wen && !busy)
            tbl_q[wr.addr] <= wr.data;
    end

    assign rd_bit = tbl_q[rd_addr];

    p_write_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && wr.wen) |=> $stable(tbl_q));

    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr.wen) |=> (tbl_q[$past(wr.addr)] == $past(wr.data)));
endmodule

// File: rtl/pwl_interp_acc.sv
module pwl_interp_acc
    import pwl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   step,
    input  logic   hit,
    input  logic   last,
    output acc_t   acc,
    output level_t res,
    output logic   res_vld
);
    acc_t   acc_q;
    acc_t   acc_nx;
    level_t res_q;
    logic   vld_q;

    always_comb acc_nx = acc_q + acc_t'(hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (clr)
                acc_q <= '0;
            else if (step)
                acc_q <= acc_nx;
            if (last) begin
                res_q <= clip_acc(acc_nx);
                vld_q <= 1'b1;
            end
        end
    end

    assign acc     = acc_q;
    assign res     = res_q;
    assign res_vld = vld_q;

    p_vld_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        res_vld |=> !res_vld);

    p_res_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !res_vld |-> $stable(res));
endmodule

// File: rtl/pwl_simplex_eval.sv
module pwl_simplex_eval
    import pwl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [N_IN*DW-1:0]   samples,
    input  logic                 wr_en,
    input  logic [N_IN-1:0]      wr_addr,
    input  logic                 wr_data,
    output logic [DW-1:0]        res,
    output logic                 res_vld
);
    ctl_state_e state_q;
    logic       running;
    logic       load;
    logic       last;
    vcode_t     code;
    level_t     ramp;
    logic       hit;
    acc_t       acc;
    tbl_wr_t    wr_req;

    assign running = (state_q == ST_SWEEP);
    assign load    = start && !running;
    assign wr_req  = '{wen: wr_en, addr: wr_addr, data: wr_data};

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else if (load)
            state_q <= ST_SWEEP;
        else if (last)
            state_q <= ST_IDLE;
    end

    pwl_vertex_gen u_vgen (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .running (running),
        .samples (samples),
        .code    (code),
        .ramp    (ramp),
        .last    (last)
    );

    pwl_param_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .busy    (running),
        .wr      (wr_req),
        .rd_addr (code),
        .rd_bit  (hit)
    );

    pwl_interp_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (load),
        .step    (running),
        .hit     (hit),
        .last    (last),
        .acc     (acc),
        .res     (res),
        .res_vld (res_vld)
    );

    p_acc_bound_r5: assert property (@(posedge clk) disable iff (rst)
        running |-> (acc <= {1'b0, ramp}));

    p_restart_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (running && start && !last) |=> (running && ramp == $past(ramp) + 1'b1));

    p_vld_after_sweep_r7: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> (!running && $past(running)));
endmodule

// File: tb/tb_pwl_simplex_eval.sv
module tb_pwl_simplex_eval;
    import pwl_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [N_IN*DW-1:0]  samples = '0;
    logic                wr_en = 1'b0;
    logic [N_IN-1:0]     wr_addr = '0;
    logic                wr_data = 1'b0;
    logic [DW-1:0]       res;
    logic                res_vld;

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    bit model [DEPTH];

    typedef struct { int val; int due; string req; } exp_t;
    exp_t sb [$];

    pwl_simplex_eval dut (
        .clk(clk), .rst(rst), .start(start), .samples(samples),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .res(res), .res_vld(res_vld)
    );

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int predict(logic [N_IN*DW-1:0] s);
        int sum = 0;
        for (int r = 0; r < STEPS; r++) begin
            int a = 0;
            for (int i = 0; i < N_IN; i++)
                if (int'(s[i*DW +: DW]) >= r) a |= (1 << i);
            sum += int'(model[a]);
        end
        return (sum > STEPS - 1) ? STEPS - 1 : sum;
    endfunction

    function automatic bit pat_bit(int pat, int a);
        case (pat)
            0: return 1'b0;
            1: return 1'b1;
            2: return bit'(a == DEPTH - 1);
            3: return bit'($countones(a) % 2);
            4: return bit'((a >> 4) & 1);
            default: return bit'(((a * 37) >> 3) & 1);
        endcase
    endfunction

    task automatic load_tbl(int pat);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = N_IN'(a); wr_data = pat_bit(pat, a);
            model[a] = pat_bit(pat, a);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // mode 0 plain, 1 second start mid-sweep, 2 write mid-sweep, 3 samples change mid-sweep
    task automatic run_eval(logic [N_IN*DW-1:0] s, int mode, string req);
        int e;
        @(negedge clk);
        samples = s;
        start = 1'b1;
        e = predict(s);
        sb.push_back('{e, cyc + 257, req});
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        case (mode)
            1: begin start = 1'b1; @(negedge clk); start = 1'b0; end
            2: begin
                wr_en = 1'b1; wr_addr = '1; wr_data = ~model[DEPTH-1];
                @(negedge clk);
                wr_en = 1'b0;
            end
            3: samples = ~s;
            default: ;
        endcase
        for (int k = 0; k < 400 && sb.size() > 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk({req, " R7 hold"}, int'(res), e);
    endtask

    function automatic logic [N_IN*DW-1:0] mk(int a0, int a1, int a2, int a3, int a4,
                                             int a5, int a6, int a7, int a8);
        return {DW'(a8), DW'(a7), DW'(a6), DW'(a5), DW'(a4),
                DW'(a3), DW'(a2), DW'(a1), DW'(a0)};
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (res_vld) begin
                if (sb.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R7 unexpected strobe actual=1 expected=0");
                end else begin
                    exp_t x;
                    x = sb.pop_front();
                    chk(x.req, int'(res), x.val);
                    chk({x.req, " R7 latency"}, cyc, x.due);
                end
            end else if (sb.size() > 0 && cyc > sb[0].due) begin
                exp_t x;
                x = sb.pop_front();
                n_cmp++; n_bad++;
                $display("FAIL %s R7 missing strobe actual=%0d expected=%0d", x.req, cyc, x.due);
            end
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) model[a] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 res", int'(res), 0);
        chk("R1 res_vld", int'(res_vld), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle", int'(res_vld), 0);

        run_eval(mk(200, 10, 50, 90, 128, 255, 0, 33, 77), 0, "R1 table cleared");

        load_tbl(1);
        run_eval(mk(5, 6, 7, 8, 9, 10, 11, 12, 13), 0, "R5 saturate");

        load_tbl(2);
        run_eval(mk(120, 99, 200, 250, 180, 101, 140, 160, 230), 0, "R2 min plus one");
        run_eval(mk(120, 99, 200, 250, 0, 101, 140, 160, 230), 0, "R2 zero input");
        run_eval(mk(255, 255, 255, 255, 255, 255, 255, 255, 255), 0, "R2 R5 all max");

        load_tbl(3);
        run_eval(mk(17, 240, 63, 128, 199, 5, 90, 150, 33), 0, "R3 R4 parity a");
        run_eval(mk(0, 255, 128, 64, 32, 16, 8, 4, 2), 0, "R3 R4 parity b");

        load_tbl(4);
        run_eval(mk(10, 20, 30, 40, 170, 50, 60, 70, 80), 0, "R2 centre bit");

        load_tbl(5);
        run_eval(mk(77, 13, 201, 144, 66, 250, 39, 180, 111), 0, "R3 R5 hashed");
        run_eval(mk(77, 13, 201, 144, 66, 250, 39, 180, 111), 1, "R8 restart ignored");
        run_eval(mk(255, 3, 99, 140, 60, 222, 18, 175, 130), 2, "R6 busy write");
        run_eval(mk(255, 3, 99, 140, 60, 222, 18, 175, 130), 0, "R6 table unchanged");
        run_eval(mk(44, 199, 88, 12, 250, 160, 71, 5, 133), 3, "R9 samples latched");

        report();
    end
endmodule